// File: doc/BRIEF.md
# Terminal Address Latch and Parity Check

This block holds the 5-bit terminal address of a serial-bus remote terminal, together with its parity bit, and decides whether an incoming command should get no response. The address can be taken from five strap pins plus a parity strap, or from the low six bits of the host data bus. A latch-control pin picks one of three capture modes. With the pin held low, the register follows the straps. When the pin rises, the register captures the straps once. With the pin held high, the host loads the register through a short sequence of configuration writes.

Three configuration bits live in a small local register model: an extended-operation enable, a host-load enable and a source select. A write to a dedicated load register captures the address only when the first two bits are already set. The source-select bit then decides whether the straps or the written data supply the value. The block checks the held address for odd parity. It compares each command address with the held address, treats address 31 as the broadcast address, and raises a no-response flag for any command it must not answer.

Top module: `term_addr_latch`

## Requirements
- R1: Reset clears all three configuration bits. On the first clock edge after reset is released, the held address and parity are loaded from the straps, whatever level the latch-control pin has.
- R2: While the synchronized latch-control level is 0, the held address and parity take the strap values on every clock edge, so they follow a strap change one cycle later.
- R3: The latch-control pin passes through two synchronizer flops. When it goes from 0 to 1, the straps are captured on the third clock edge after the change, and later strap changes have no effect while the pin stays high.
- R4: Register select 0 holds the extended-operation bit at data bit 15. Register select 1 holds the host-load enable at data bit 3. A write to register select 2 loads the address only if both bits are already 1 and the synchronized latch-control level is 1. Otherwise the write leaves the held value unchanged.
- R5: Register select 3 holds the source-select bit at data bit 5. When this bit is 1, a loading write takes the address from data bits 5..1, with bit 5 as the most significant bit, and the parity from data bit 0.
- R6: When the source-select bit is 0, a loading write captures the strap values, and data bits 5..0 are ignored.
- R7: The parity-valid output is 1 exactly when the held address bits and the held parity bit together contain an odd number of ones.
- R8: When a command is valid and its address is neither 31 nor the held address, the no-response output is 1. When a command is valid and matches the held address with valid parity, the output is 0. It is 0 whenever no command is valid.
- R9: When parity is invalid, a valid command to the held address that is not 31 still gives no-response 1.
- R10: A valid command to address 31 always gives no-response 0, whatever the parity result.
- R11: While the synchronized latch-control level is 0, a loading write with the bus source selected does not replace the strap-following value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | Address straps |
| strap_par | input | 1 | Parity strap |
| latch_pin | input | 1 | Asynchronous latch-control pin |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select (0 mode, 1 option, 2 load, 3 source) |
| host_wdata | input | 16 | Host write data |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_addr | input | 5 | Address field of the command |
| term_addr | output | 5 | Held terminal address |
| term_par | output | 1 | Held parity bit |
| par_ok | output | 1 | Held address has odd parity |
| no_resp | output | 1 | Command must not be answered |

## Verification
The held address is the only state that reaches the outputs. If a load fires in the wrong mode or on the wrong source, or fails to fire, term_addr shows the wrong value one cycle after the write or strap change. A wrong register bit or enable stays hidden until the next write to the load register, and shows up one cycle after that write. If the synchronizer has the wrong depth or the edge detector is wrong, the capture lands on the wrong cycle, and a strap change made a few cycles after the rise shows this. A parity or response fault appears as soon as the command inputs are applied, with no delay.

// File: rtl/tal_pkg.sv
package tal_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_OPT   = 2'd1,
    REG_ALOAD = 2'd2,
    REG_SRC   = 2'd3
  } reg_sel_e;

  // odd number of ones over address and parity
  function automatic logic parity_odd(input logic [ADDR_W-1:0] a, input logic p);
    return ^{a, p};
  endfunction

  // 1 when the command must be answered
  function automatic logic cmd_accept(input logic [ADDR_W-1:0] cmd,
                                      input logic [ADDR_W-1:0] held,
                                      input logic pok);
    return (cmd == BCAST_ADDR) || ((cmd == held) && pok);
  endfunction
endpackage

// File: rtl/tal_cfg_regs.sv
module tal_cfg_regs #(
  parameter int DATA_W  = 16,
  parameter int ENH_BIT = 15,
  parameter int LEN_BIT = 3,
  parameter int SRC_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              enh,
  output logic              len,
  output logic              src_bus,
  output logic              aload_wr
);
  import tal_pkg::*;

  logic unused_bits;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh     <= 1'b0;
      len     <= 1'b0;
      src_bus <= 1'b0;
    end else if (wr) begin
      if (sel == REG_MODE) enh     <= wdata[ENH_BIT];
      if (sel == REG_OPT)  len     <= wdata[LEN_BIT];
      if (sel == REG_SRC)  src_bus <= wdata[SRC_BIT];
    end
  end

  assign aload_wr = wr && (sel == REG_ALOAD);
endmodule

// File: rtl/tal_sync_edge.sv
module tal_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sh[i] <= 1'b0;
        else        sh[i] <= sh[i-1];
      end
    end
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tal_addr_latch.sv
module tal_addr_latch #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_par,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_par,
  input  logic              level,
  input  logic              rise,
  input  logic              aload_wr,
  input  logic              enh,
  input  logic              len,
  input  logic              src_bus,
  output logic [ADDR_W-1:0] addr_q,
  output logic              par_q,
  output logic              load_pin_ev,
  output logic              load_host_ev
);
  logic init_q;

  assign load_pin_ev  = init_q | ~level | rise;
  assign load_host_ev = ~load_pin_ev & aload_wr & enh & len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      addr_q <= '0;
      par_q  <= 1'b0;
    end else begin
      init_q <= 1'b0;
      if (load_pin_ev || (load_host_ev && !src_bus)) begin
        addr_q <= strap_addr;
        par_q  <= strap_par;
      end else if (load_host_ev) begin
        addr_q <= bus_addr;
        par_q  <= bus_par;
      end
    end
  end
endmodule

// File: rtl/tal_resp_check.sv
module tal_resp_check #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] held_addr,
  input  logic              held_par,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              par_ok,
  output logic              no_resp
);
  import tal_pkg::*;

  assign par_ok  = parity_odd(held_addr, held_par);
  assign no_resp = cmd_valid && !cmd_accept(cmd_addr, held_addr, par_ok);
endmodule

// File: rtl/term_addr_latch.sv
module term_addr_latch #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [tal_pkg::ADDR_W-1:0] strap_addr,
  input  logic                      strap_par,
  input  logic                      latch_pin,
  input  logic                      host_wr,
  input  logic [1:0]                host_sel,
  input  logic [DATA_W-1:0]         host_wdata,
  input  logic                      cmd_valid,
  input  logic [tal_pkg::ADDR_W-1:0] cmd_addr,
  output logic [tal_pkg::ADDR_W-1:0] term_addr,
  output logic                      term_par,
  output logic                      par_ok,
  output logic                      no_resp
);
  import tal_pkg::*;

  localparam int BUS_LSB = 1;
  localparam int BUS_MSB = BUS_LSB + ADDR_W - 1;

  logic enh, len, src_bus, aload_wr;
  logic lvl, rise;
  logic load_pin_ev, load_host_ev;

  tal_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel), .wdata(host_wdata),
    .enh(enh), .len(len), .src_bus(src_bus), .aload_wr(aload_wr)
  );

  tal_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(latch_pin), .level(lvl), .rise(rise)
  );

  tal_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .strap_addr(strap_addr), .strap_par(strap_par),
    .bus_addr(host_wdata[BUS_MSB:BUS_LSB]), .bus_par(host_wdata[0]),
    .level(lvl), .rise(rise), .aload_wr(aload_wr),
    .enh(enh), .len(len), .src_bus(src_bus),
    .addr_q(term_addr), .par_q(term_par),
    .load_pin_ev(load_pin_ev), .load_host_ev(load_host_ev)
  );

  tal_resp_check #(.ADDR_W(ADDR_W)) u_resp (
    .held_addr(term_addr), .held_par(term_par),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .par_ok(par_ok), .no_resp(no_resp)
  );
endmodule

// File: rtl/tal_chk.sv
module tal_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] strap_addr,
  input logic       strap_par,
  input logic [5:0] bus_low,
  input logic       lvl,
  input logic       enh,
  input logic       len,
  input logic       src_bus,
  input logic       load_pin_ev,
  input logic       load_host_ev,
  input logic [4:0] term_addr,
  input logic       term_par,
  input logic       par_ok,
  input logic       cmd_valid,
  input logic [4:0] cmd_addr,
  input logic       no_resp
);
  // R2
  low_level_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |-> load_pin_ev);

  // R2
  pin_load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_pin_ev |=> (term_addr == $past(strap_addr)) && (term_par == $past(strap_par)));

  // R4
  host_load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_host_ev |-> (enh && len && lvl));

  // R5
  bus_load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_host_ev && src_bus) |=> (term_addr == $past(bus_low[5:1])) && (term_par == $past(bus_low[0])));

  // R6
  strap_host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_host_ev && !src_bus) |=> (term_addr == $past(strap_addr)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pin_ev && !load_host_ev) |=> ($stable(term_addr) && $stable(term_par)));

  // R7
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_ok == ($countones({term_addr, term_par}) % 2 == 1));

  // R10
  bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == 5'h1F) |-> !no_resp);

  // R9
  bad_par_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !par_ok && cmd_addr != 5'h1F) |-> no_resp);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !no_resp);
endmodule

bind term_addr_latch tal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .strap_par(strap_par),
  .bus_low(host_wdata[5:0]), .lvl(lvl), .enh(enh), .len(len), .src_bus(src_bus),
  .load_pin_ev(load_pin_ev), .load_host_ev(load_host_ev),
  .term_addr(term_addr), .term_par(term_par), .par_ok(par_ok),
  .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .no_resp(no_resp)
);

// File: tb/tb_term_addr_latch.sv
module tb_term_addr_latch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap_addr;
  logic        strap_par;
  logic        latch_pin;
  logic        host_wr;
  logic [1:0]  host_sel;
  logic [15:0] host_wdata;
  logic        cmd_valid;
  logic [4:0]  cmd_addr;
  logic [4:0]  term_addr;
  logic        term_par, par_ok, no_resp;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  term_addr_latch dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic exp_pok(input logic [4:0] a, input logic p);
    return ($countones(a) + p) % 2 == 1;
  endfunction

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = 16'h0;
  endtask

  task automatic probe(input logic [4:0] a, input logic [4:0] exp_addr,
                       input logic exp_p, input string what);
    logic e;
    cmd_valid = 1'b1; cmd_addr = a;
    #1;
    e = !((a == 5'h1F) || ((a == exp_addr) && exp_pok(exp_addr, exp_p)));
    check(no_resp, e, what);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; latch_pin = 1'b1;
    strap_addr = 5'h0B; strap_par = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(term_addr, 5'h0B, "R1 addr loaded after reset");
    check(par_ok, 1, "R1/R7 par_ok after reset");
    cycles(4);
    strap_addr = 5'h05; strap_par = 1'b1;
    cycles(2);
    check(term_addr, 5'h0B, "R3 straps ignored while pin high");
  endtask

  task automatic t_host_gate;
    host_write(2'd2, 16'h003F);
    check(term_addr, 5'h0B, "R1/R4 load with cleared config");
    host_write(2'd0, 16'h8000);
    host_write(2'd2, 16'h003F);
    check(term_addr, 5'h0B, "R4 load with only mode bit");
    host_write(2'd1, 16'h0008);
    host_write(2'd2, 16'h003F);
    check(term_addr, 5'h05, "R6 strap source, data ignored");
    check(term_par, 1, "R6 strap parity captured");
  endtask

  task automatic t_host_bus;
    host_write(2'd3, 16'h0020);
    host_write(2'd2, {10'h0, 5'h12, 1'b1});
    check(term_addr, 5'h12, "R5 bus address");
    check(term_par, 1, "R5 bus parity");
    check(par_ok, exp_pok(5'h12, 1'b1), "R7 good parity");
    host_write(2'd2, {10'h0, 5'h12, 1'b0});
    check(par_ok, exp_pok(5'h12, 1'b0), "R7 bad parity");
    probe(5'h12, 5'h12, 1'b0, "R9 matched addr, bad parity");
    probe(5'h1F, 5'h12, 1'b0, "R10 broadcast with bad parity");
  endtask

  task automatic t_transparent;
    latch_pin = 1'b0;
    cycles(4);
    strap_addr = 5'h07; strap_par = 1'b0;
    @(negedge clk);
    check(term_addr, 5'h07, "R2 follows straps");
    check(par_ok, exp_pok(5'h07, 1'b0), "R2/R7 parity follows");
    strap_addr = 5'h03; strap_par = 1'b0;
    @(negedge clk);
    check(term_addr, 5'h03, "R2 second strap value");
    check(par_ok, exp_pok(5'h03, 1'b0), "R7 even count flagged");
    host_write(2'd2, {10'h0, 5'h15, 1'b0});
    check(term_addr, 5'h03, "R11 bus load ignored when pin low");
  endtask

  task automatic t_edge;
    strap_addr = 5'h1C; strap_par = 1'b0;
    latch_pin = 1'b1;
    cycles(2);
    check(term_addr, 5'h1C, "R3 value before capture");
    cycles(2);
    strap_addr = 5'h01; strap_par = 1'b1;
    cycles(2);
    check(term_addr, 5'h1C, "R3 captured on rise");
    check(term_par, 0, "R3 parity captured on rise");
  endtask

  task automatic t_resp;
    probe(5'h1C, 5'h1C, 1'b0, "R8 matched addr answered");
    probe(5'h1D, 5'h1C, 1'b0, "R8 mismatch not answered");
    probe(5'h1F, 5'h1C, 1'b0, "R10 broadcast good parity");
    cmd_valid = 1'b0; cmd_addr = 5'h04;
    #1;
    check(no_resp, 0, "R8 quiet without command");
  endtask

  initial begin
    host_wr = 1'b0; host_sel = 2'd0; host_wdata = 16'h0;
    cmd_valid = 1'b0; cmd_addr = 5'h0;
    @(negedge clk);
    t_reset();
    t_host_gate();
    t_host_bus();
    t_transparent();
    t_edge();
    t_resp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule